// File: doc/BRIEF.md
# Overload Auto-Restart Sequencer

This block guards a cycle-by-cycle switching regulator against sustained overload. Each oscillator period shows up as a one-cycle slot strobe. At each slot the block decides whether the power switch may conduct in that period. A slot is withheld when the regulation feedback asks for it, or when the previous pulse conducted for too short a time. Otherwise the slot becomes an enabled pulse, and a counter of consecutive enabled pulses advances.

Feedback that withholds a pulse shows the output is in regulation, so it clears the counter. If the counter reaches its terminal value, the regulator has been delivering every permitted pulse without ever reaching regulation. The block then stops switching for a long off interval, spends one slot in a restart state, and resumes with a cleared count.

Slots dropped by the short-conduction rule neither advance nor clear the counter. When many slots are dropped, the time spent switching before a fault stretches in proportion to the drop ratio. The oscillator period itself never changes.

Top module: `ovl_autorestart`

## Requirements
- R1: A synchronous active-high `rst` puts the block in the run state with `gate_en` low, `fault` low, `state` = 0, and the pulse, skip and off counters cleared.
- R2: In the run state, a slot that is not skipped, not inhibited and not terminal drives `gate_en` high and advances the pulse count by one. `gate_en` changes only on the clock edge at which `slot` is high.
- R3: A slot with `fb_inhibit` high that is not skipped drives `gate_en` low and clears the pulse count. A full new series of pulses is then needed before a fault.
- R4: An enabled slot that finds ON_PULSES-1 pulses already counted is terminal. In that slot `gate_en` goes low, the block enters the off state and `fault` goes high. Under continuous overload, a fault therefore follows ON_PULSES-1 pulses in ON_PULSES slots.
- R5: The off state lasts exactly OFF_SLOTS slots with `gate_en` low. It is followed by one restart slot with `gate_en` low, after which the block is back in the run state with a zero count.
- R6: If `gate_en` is high when a slot arrives and `on_time` is below MIN_ON, that slot and the next SKIP_SLOTS-1 slots are skipped, with `gate_en` low. In total, SKIP_SLOTS slots are dropped after each short pulse.
- R7: A skipped slot leaves the pulse count unchanged and ignores `fb_inhibit`. When short conduction and feedback inhibit coincide, the skip takes priority.
- R8: `on_time` is ignored at a slot where `gate_en` is low, because no pulse was issued in the preceding period.
- R9: `state` encodes run as 0, off as 1 and restart as 2. `fault` is high exactly while `state` is 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| slot | input | 1 | One-cycle strobe marking each oscillator period |
| fb_inhibit | input | 1 | Regulation feedback asks to withhold this pulse |
| on_time | input | TW | Measured conduction time of the previous pulse, in clocks |
| gate_en | output | 1 | Registered switch enable for the current period |
| fault | output | 1 | High during the off interval |
| state | output | 2 | 0 run, 1 off, 2 restart |

## Verification
Two events can land in the same slot: a short-conduction skip and a feedback inhibit. The bench provokes this by issuing one pulse, then presenting `fb_inhibit` together with a short `on_time` at the next two slots. It judges the result by the number of slots left before the fault. With the skip taking priority, the count of one survives and the fault arrives one slot sooner than it would if the inhibit had cleared the count. A reference model in the scoreboard compares every slot's outputs.

// File: rtl/ovl_autorestart.sv
module ovl_autorestart #(
  parameter int unsigned ON_PULSES  = 8448,
  parameter int unsigned OFF_SLOTS  = 330000,
  parameter int unsigned TW         = 8,
  parameter int unsigned MIN_ON     = 100,
  parameter int unsigned SKIP_SLOTS = 1
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          slot,
  input  logic          fb_inhibit,
  input  logic [TW-1:0] on_time,
  output logic          gate_en,
  output logic          fault,
  output logic [1:0]    state
);
  localparam int unsigned CW = (ON_PULSES  > 2) ? $clog2(ON_PULSES)    : 1;
  localparam int unsigned OW = (OFF_SLOTS  > 2) ? $clog2(OFF_SLOTS)    : 1;
  localparam int unsigned SW = $clog2(SKIP_SLOTS + 1);
  localparam logic [1:0] S_RUN = 2'd0, S_OFF = 2'd1, S_RST = 2'd2;

  logic [CW-1:0] cnt;
  logic [OW-1:0] off_cnt;
  logic [SW-1:0] skip_left;

  wire short_pulse = gate_en && (on_time < TW'(MIN_ON));
  wire skipping    = short_pulse || (skip_left != '0);
  wire terminal    = (cnt == CW'(ON_PULSES - 1));

  assign fault = (state == S_OFF);

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= S_RUN;
      gate_en   <= 1'b0;
      cnt       <= '0;
      off_cnt   <= '0;
      skip_left <= '0;
    end else if (slot) begin
      case (state)
        S_RUN: begin
          if (skipping) begin
            gate_en   <= 1'b0;
            skip_left <= short_pulse ? SW'(SKIP_SLOTS - 1) : skip_left - 1'b1;
          end else if (fb_inhibit) begin
            gate_en <= 1'b0;
            cnt     <= '0;
          end else if (terminal) begin
            gate_en <= 1'b0;
            cnt     <= '0;
            off_cnt <= '0;
            state   <= S_OFF;
          end else begin
            gate_en <= 1'b1;
            cnt     <= cnt + 1'b1;
          end
        end
        S_OFF: begin
          gate_en <= 1'b0;
          if (off_cnt == OW'(OFF_SLOTS - 1)) state <= S_RST;
          else off_cnt <= off_cnt + 1'b1;
        end
        default: begin
          gate_en   <= 1'b0;
          cnt       <= '0;
          skip_left <= '0;
          state     <= S_RUN;
        end
      endcase
    end
  end

  p_reset_r1: assert property (@(posedge clk) rst |=> (state == S_RUN && !gate_en && cnt == '0));

  p_gate_on_slot_r2: assert property (@(posedge clk) disable iff (rst)
    !slot |=> $stable(gate_en));

  p_inhibit_clears_r3: assert property (@(posedge clk) disable iff (rst)
    (slot && state == S_RUN && !skipping && fb_inhibit) |=> (cnt == '0 && !gate_en));

  p_fault_at_terminal_r4: assert property (@(posedge clk) disable iff (rst)
    $rose(fault) |-> ($past(cnt) == CW'(ON_PULSES - 1)));

  p_no_gate_when_off_r5: assert property (@(posedge clk) disable iff (rst)
    (state != S_RUN) |-> !gate_en);

  p_skip_holds_count_r7: assert property (@(posedge clk) disable iff (rst)
    (slot && state == S_RUN && skipping) |=> (cnt == $past(cnt) && !gate_en));

  p_state_legal_r9: assert property (@(posedge clk) disable iff (rst)
    state != 2'd3);
endmodule

// File: tb/ovl_autorestart_tb.sv
module ovl_autorestart_tb;
  localparam int ON = 8, OFF = 5, MINON = 10, SKIP = 2;
  localparam logic [7:0] SHORT_T = 8'd3, LONG_T = 8'd50;

  logic clk = 1'b0, rst = 1'b1, slot = 1'b0, fb = 1'b0;
  logic [7:0] ot = LONG_T;
  logic gate_en, fault;
  logic [1:0] state;

  always #2 clk = ~clk;

  ovl_autorestart #(.ON_PULSES(ON), .OFF_SLOTS(OFF), .TW(8), .MIN_ON(MINON), .SKIP_SLOTS(SKIP)) u_dut (
    .clk(clk), .rst(rst), .slot(slot), .fb_inhibit(fb), .on_time(ot),
    .gate_en(gate_en), .fault(fault), .state(state));

  int n_chk = 0, n_bad = 0;
  logic [3:0] q[$];
  string tq[$];

  int m_cnt, m_skip, m_off, m_state;
  logic m_gate;

  task automatic chk(input bit ok, input string req, input int act, input int exp);
    n_chk++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
    end
  endtask

  always @(negedge clk) begin
    #1;
    while (q.size() > 0) begin
      logic [3:0] e;
      string t;
      e = q.pop_front();
      t = tq.pop_front();
      chk({gate_en, fault, state} == e, t, int'({gate_en, fault, state}), int'(e));
    end
  end

  task automatic model(input logic f, input logic [7:0] t);
    if (m_state == 0) begin
      bit sh;
      sh = m_gate && (t < MINON);
      if (sh || m_skip != 0) begin
        m_gate = 0;
        m_skip = sh ? SKIP - 1 : m_skip - 1;
      end else if (f) begin
        m_gate = 0; m_cnt = 0;
      end else if (m_cnt == ON - 1) begin
        m_gate = 0; m_cnt = 0; m_off = 0; m_state = 1;
      end else begin
        m_gate = 1; m_cnt++;
      end
    end else if (m_state == 1) begin
      m_gate = 0;
      if (m_off == OFF - 1) m_state = 2; else m_off++;
    end else begin
      m_gate = 0; m_cnt = 0; m_skip = 0; m_state = 0;
    end
  endtask

  task automatic do_slot(input logic f, input logic [7:0] t);
    logic [3:0] e;
    @(negedge clk);
    slot = 1'b1; fb = f; ot = t;
    model(f, t);
    e = {m_gate, (m_state == 1), 2'(m_state)};
    @(negedge clk);
    slot = 1'b0; fb = 1'b0; ot = LONG_T;
    q.push_back(e); tq.push_back("R2/R9 model slot");
    @(negedge clk);
    q.push_back(e); tq.push_back("R2 hold between slots");
  endtask

  task automatic do_reset();
    @(negedge clk);
    rst = 1'b1;
    @(negedge clk);
    @(negedge clk);
    rst = 1'b0;
    m_cnt = 0; m_skip = 0; m_off = 0; m_state = 0; m_gate = 0;
    #1;
    chk(!gate_en && !fault && state == 2'd0, "R1 reset state", int'({gate_en, fault, state}), 0);
  endtask

  task automatic slots_to_fault(input logic [7:0] t, output int slots, output int pulses);
    slots = 0; pulses = 0;
    for (int i = 0; i < 60 && !fault; i++) begin
      do_slot(1'b0, t);
      slots++;
      if (gate_en) pulses++;
    end
  endtask

  task automatic finish_off();
    for (int i = 0; i < 20 && state != 2'd0; i++) do_slot(1'b0, LONG_T);
  endtask

  task automatic summary();
    $display("  == %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  endtask

  initial begin
    #(4 * 150000);
    n_bad++;
    $display("FAIL watchdog: run did not complete");
    summary();
  end

  initial begin
    int s, p, fs;
    m_cnt = 0; m_skip = 0; m_off = 0; m_state = 0; m_gate = 0;
    repeat (3) @(negedge clk);
    do_reset();

    // R4 R2: continuous overload
    slots_to_fault(LONG_T, s, p);
    chk(p == ON - 1, "R4 pulses before fault", p, ON - 1);
    chk(s == ON, "R4 slots to fault", s, ON);

    // R5 R9: off interval
    fs = 1;
    for (int i = 0; i < 20 && state == 2'd1; i++) begin
      do_slot(1'b0, LONG_T);
      if (state == 2'd1) fs++;
    end
    chk(fs == OFF, "R5 off slots", fs, OFF);
    chk(state == 2'd2 && !fault && !gate_en, "R9 restart state", int'(state), 2);
    do_slot(1'b0, LONG_T);
    chk(state == 2'd0 && !gate_en, "R5 back to run", int'(state), 0);

    // R3: inhibit clears count
    repeat (5) do_slot(1'b0, LONG_T);
    do_slot(1'b1, LONG_T);
    chk(!gate_en, "R3 inhibited slot gate", int'(gate_en), 0);
    slots_to_fault(LONG_T, s, p);
    chk(s == ON, "R3 slots to fault after inhibit", s, ON);
    finish_off();

    // R6: short conduction stretches the window
    slots_to_fault(SHORT_T, s, p);
    chk(p == ON - 1, "R6 pulses with skipping", p, ON - 1);
    chk(s == (ON - 1) * (SKIP + 1) + 1, "R6 stretched slots to fault", s, (ON - 1) * (SKIP + 1) + 1);
    finish_off();

    // R7: skip and inhibit in the same slot
    do_slot(1'b0, LONG_T);
    do_slot(1'b1, SHORT_T);
    chk(!gate_en, "R7 skip over inhibit gate", int'(gate_en), 0);
    do_slot(1'b1, SHORT_T);
    slots_to_fault(LONG_T, s, p);
    chk(s == ON - 1, "R7 count kept through skipped inhibit", s, ON - 1);
    finish_off();

    // R8: on_time ignored when no pulse
    do_slot(1'b1, SHORT_T);
    do_slot(1'b0, SHORT_T);
    chk(gate_en, "R8 short on_time ignored after idle slot", int'(gate_en), 1);

    // R1: reset mid-run clears the count
    repeat (4) do_slot(1'b0, LONG_T);
    do_reset();
    slots_to_fault(LONG_T, s, p);
    chk(s == ON, "R1 count cleared by reset", s, ON);

    repeat (3) @(negedge clk);
    summary();
  end
endmodule